// File: doc/BRIEF.md
# Warp Memory Transaction Coalescer

The coalescer takes a single warp-wide memory request and breaks it into a stream of aligned memory transactions. The request carries one address per lane, an active-lane mask, a common access size and an atomic flag. Each transaction is either 32, 64 or 128 bytes long. It carries a base address, the mask of lanes it serves, and a byte-enable mask. The byte-enable mask covers the 128-byte aligned region that contains the transaction.

Lanes are handled in sub-groups. Active lanes of one sub-group whose addresses fall in the same aligned segment are merged into a single transaction. The segment length depends on the access size. Each merged transaction is then cut down, a half at a time, to the smallest aligned piece that still covers its 32-byte chunks.

In atomic mode the warp is always split into two sub-groups. Lanes whose bytes would collide inside a transaction are placed in separate transactions. A lane joins the first earlier transaction for its segment that it does not collide with.

The request is accepted on a ready/valid handshake while the block is idle. Transactions leave on a second ready/valid stream, one per accepted beat. A last flag marks the final transaction of a request.

Top module: `warp_coalescer`

## Requirements
- R1: The segment length follows the access size code `req_size`: code 0 (1 byte) gives 32-byte segments, code 1 (2 bytes) gives 64-byte segments, and codes 2, 3 and 4 (4, 8 and 16 bytes) give 128-byte segments. A lane's segment base is its address rounded down to the segment length.
- R2: All active lanes of one sub-group that share a segment base are served by exactly one transaction (outside atomic mode). `tx_lanes` bit i is set exactly for the lanes served.
- R3: `tx_bytes` bit k means that byte k of the 128-byte aligned region containing `tx_addr` is accessed. Each served lane sets `1 << req_size` consecutive bits starting at its address modulo 128. Lane addresses are aligned to the access size.
- R4: A 128-byte segment whose used 32-byte chunks all lie in chunks 0–1 is sent as 64 bytes at the segment base. If they all lie in chunks 2–3, it is sent as 64 bytes at base + 64. Otherwise it is sent as 128 bytes.
- R5: A 64-byte piece is sent as 32 bytes if only one of its two 32-byte halves is used, with the address moved up by 32 when that half is the upper one. For a native 64-byte segment, the halves are chunks 0–1 when the base modulo 128 is 0 and chunks 2–3 when it is 64. `tx_size` encodes 0 = 32, 1 = 64, 2 = 128 bytes, and `tx_addr` is aligned to it.
- R6: With `req_atomic` set, the warp splits into two equal sub-groups of consecutive lanes. In lane order, a lane joins the first transaction of its segment that has none of its bytes set. Otherwise it opens a new transaction after the existing ones.
- R7: Transactions are emitted in sub-group order, lowest sub-group first. Within a sub-group they are emitted in ascending segment base order. Transactions that share a base, which happens only in atomic mode, keep their creation order.
- R8: A request with an all-zero lane mask is accepted and produces no transaction. `req_ready` stays high after it.
- R9: `req_ready` is low while transactions of the current request remain. While `tx_valid` is high and `tx_ready` is low, every `tx_*` output holds. `tx_last` is high only on the final transaction, and `req_ready` is high in the cycle after that transaction is taken.
- R10: Outside atomic mode, the warp splits into `PARTS` equal sub-groups of consecutive lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_atomic | input | 1 | Atomic mode: split colliding lanes |
| req_size | input | 3 | Access size code, bytes = 1 << code (0..4) |
| req_mask | input | LANES | Active lanes |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits i*ADDR_W |
| tx_valid | output | 1 | Transaction offered |
| tx_ready | input | 1 | Transaction taken |
| tx_addr | output | ADDR_W | Transaction byte address |
| tx_size | output | 2 | 0 = 32, 1 = 64, 2 = 128 bytes |
| tx_lanes | output | LANES | Lanes served by this transaction |
| tx_bytes | output | 128 | Byte enables over the enclosing 128-byte region |
| tx_last | output | 1 | Final transaction of the request |

## Verification
The assertions take for granted that a request carries a size code no larger than 4. They also assume that every active lane address is a multiple of its access size, so a lane never straddles a 32-byte chunk. Under those inputs, the atomic-mode byte count and the window check on `tx_bytes` are exact. The bench builds every lane address by masking off the low bits below the access size, including the random patterns, and only ever drives codes 0 to 4. The bench keeps `req_valid` high for a single cycle, and only while `req_ready` is high, so no request arrives mid-stream.

// File: rtl/coal_pkg.sv
package coal_pkg;

   localparam int unsigned REGION_BYTES = 128;
   localparam int unsigned CHUNK_BYTES  = 32;
   localparam int unsigned CHUNKS       = REGION_BYTES / CHUNK_BYTES;

   typedef enum logic [2:0] {
      ACC_1B  = 3'd0,
      ACC_2B  = 3'd1,
      ACC_4B  = 3'd2,
      ACC_8B  = 3'd3,
      ACC_16B = 3'd4
   } acc_size_e;

   typedef enum logic [1:0] {
      TX_32B  = 2'd0,
      TX_64B  = 2'd1,
      TX_128B = 2'd2
   } tx_size_e;

   // segment length chosen by the access size
   function automatic tx_size_e seg_of(input logic [2:0] sz);
      case (sz)
         ACC_1B:  return TX_32B;
         ACC_2B:  return TX_64B;
         default: return TX_128B;
      endcase
   endfunction

   function automatic logic [4:0] acc_bytes(input logic [2:0] sz);
      return 5'd1 << sz;
   endfunction

   // len consecutive ones starting at bit off; len of 128 gives all ones
   function automatic logic [REGION_BYTES-1:0] span_mask(input logic [6:0] off,
                                                          input logic [7:0] len);
      return ((REGION_BYTES'(1) << len) - REGION_BYTES'(1)) << off;
   endfunction

endpackage

// File: rtl/coal_lane_decode.sv
module coal_lane_decode
   import coal_pkg::*;
#(
   parameter int unsigned LANES  = 8,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned PARTS  = 2,
   parameter int unsigned SG_W   = 1
) (
   input  logic [LANES*ADDR_W-1:0]       addr_i,
   input  logic [2:0]                    size_i,
   input  logic                          atomic_i,
   output logic [LANES*ADDR_W-1:0]       base_o,
   output logic [LANES*SG_W-1:0]         sg_o,
   output logic [LANES*REGION_BYTES-1:0] bytes_o,
   output logic [LANES*CHUNKS-1:0]       chunks_o
);

   localparam int unsigned GRP_N = LANES / PARTS;
   localparam int unsigned GRP_A = LANES / 2;

   tx_size_e          seg;
   logic [ADDR_W-1:0] seg_keep;
   logic [7:0]        lane_len;

   assign seg      = seg_of(size_i);
   assign lane_len = {3'b000, acc_bytes(size_i)};

   always_comb begin
      case (seg)
         TX_32B:  seg_keep = ~ADDR_W'(31);
         TX_64B:  seg_keep = ~ADDR_W'(63);
         default: seg_keep = ~ADDR_W'(127);
      endcase
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int SG_N = l / GRP_N;
      localparam int SG_A = l / GRP_A;

      logic [ADDR_W-1:0]       a;
      logic [REGION_BYTES-1:0] lb;

      assign a  = addr_i[l*ADDR_W +: ADDR_W];
      assign lb = span_mask(a[6:0], lane_len);

      assign base_o[l*ADDR_W +: ADDR_W]             = a & seg_keep;
      assign bytes_o[l*REGION_BYTES +: REGION_BYTES] = lb;

      // with two parts the normal and atomic splits coincide
      if (PARTS == 2) begin : g_same_split
         assign sg_o[l*SG_W +: SG_W] = SG_W'(SG_N);
      end else begin : g_mux_split
         assign sg_o[l*SG_W +: SG_W] = atomic_i ? SG_W'(SG_A) : SG_W'(SG_N);
      end

      for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
         assign chunks_o[l*CHUNKS + c] = |lb[c*CHUNK_BYTES +: CHUNK_BYTES];
      end
   end

endmodule

// File: rtl/coal_pick.sv
module coal_pick #(
   parameter int unsigned LANES = 8,
   parameter int unsigned KEY_W = 17,
   parameter int unsigned IDX_W = 3
) (
   input  logic [LANES-1:0]       pend_i,
   input  logic [LANES*KEY_W-1:0] key_i,
   output logic [IDX_W-1:0]       lead_o
);

   // pending lane with the smallest {sub-group, base}; lowest index on a tie
   logic             found;
   logic [KEY_W-1:0] best;

   always_comb begin
      found  = 1'b0;
      best   = '0;
      lead_o = '0;
      for (int l = 0; l < LANES; l++) begin
         if (pend_i[l] && (!found || key_i[l*KEY_W +: KEY_W] < best)) begin
            found  = 1'b1;
            best   = key_i[l*KEY_W +: KEY_W];
            lead_o = IDX_W'(l);
         end
      end
   end

endmodule

// File: rtl/coal_group.sv
module coal_group
   import coal_pkg::*;
#(
   parameter int unsigned LANES  = 8,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned SG_W   = 1,
   parameter int unsigned IDX_W  = 3
) (
   input  logic [LANES-1:0]              pend_i,
   input  logic [LANES*ADDR_W-1:0]       base_i,
   input  logic [LANES*SG_W-1:0]         sg_i,
   input  logic [LANES*REGION_BYTES-1:0] bytes_i,
   input  logic [LANES*CHUNKS-1:0]       chunks_i,
   input  logic [IDX_W-1:0]              lead_i,
   input  logic                          atomic_i,
   output logic [LANES-1:0]              grp_o,
   output logic [REGION_BYTES-1:0]       grp_bytes_o,
   output logic [CHUNKS-1:0]             grp_chunks_o,
   output logic [ADDR_W-1:0]             lead_base_o
);

   logic [SG_W-1:0]  lead_sg;
   logic [LANES-1:0] match;

   always_comb begin
      lead_base_o = '0;
      lead_sg     = '0;
      for (int l = 0; l < LANES; l++) begin
         if (IDX_W'(l) == lead_i) begin
            lead_base_o = base_i[l*ADDR_W +: ADDR_W];
            lead_sg     = sg_i[l*SG_W +: SG_W];
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_match
      assign match[l] = pend_i[l]
                      && (sg_i[l*SG_W +: SG_W] == lead_sg)
                      && (base_i[l*ADDR_W +: ADDR_W] == lead_base_o);
   end

   // lane-order accumulation; in atomic mode a colliding lane waits for a later pass
   always_comb begin
      grp_o        = '0;
      grp_bytes_o  = '0;
      grp_chunks_o = '0;
      for (int l = 0; l < LANES; l++) begin
         if (match[l] && (!atomic_i ||
             (grp_bytes_o & bytes_i[l*REGION_BYTES +: REGION_BYTES]) == '0)) begin
            grp_o[l]     = 1'b1;
            grp_bytes_o  = grp_bytes_o  | bytes_i[l*REGION_BYTES +: REGION_BYTES];
            grp_chunks_o = grp_chunks_o | chunks_i[l*CHUNKS +: CHUNKS];
         end
      end
   end

endmodule

// File: rtl/coal_shrink.sv
module coal_shrink
   import coal_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [2:0]        acc_size_i,
   input  logic [CHUNKS-1:0] chunks_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        size_o
);

   tx_size_e   sz;
   logic [1:0] half;
   logic       low_used;
   logic       up_used;

   assign low_used = |chunks_i[1:0];
   assign up_used  = |chunks_i[3:2];

   always_comb begin
      addr_o = base_i;
      sz     = TX_32B;
      half   = 2'b00;
      // first step: 128 down to 64
      case (seg_of(acc_size_i))
         TX_128B: begin
            if (low_used && !up_used) begin
               sz   = TX_64B;
               half = chunks_i[1:0];
            end else if (!low_used && up_used) begin
               sz     = TX_64B;
               half   = chunks_i[3:2];
               addr_o = base_i + ADDR_W'(64);
            end else begin
               sz = TX_128B;
            end
         end
         TX_64B: begin
            sz   = TX_64B;
            half = base_i[6] ? chunks_i[3:2] : chunks_i[1:0];
         end
         default: sz = TX_32B;
      endcase
      // second step: 64 down to 32
      if (sz == TX_64B) begin
         if (half == 2'b01) begin
            sz = TX_32B;
         end else if (half == 2'b10) begin
            sz     = TX_32B;
            addr_o = addr_o + ADDR_W'(32);
         end
      end
   end

   assign size_o = sz;

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
   import coal_pkg::*;
#(
   parameter int unsigned LANES  = 8,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned PARTS  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_atomic,
   input  logic [2:0]              req_size,
   input  logic [LANES-1:0]        req_mask,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   output logic                    tx_valid,
   input  logic                    tx_ready,
   output logic [ADDR_W-1:0]       tx_addr,
   output logic [1:0]              tx_size,
   output logic [LANES-1:0]        tx_lanes,
   output logic [REGION_BYTES-1:0] tx_bytes,
   output logic                    tx_last
);

   localparam int unsigned NSG   = (PARTS > 2) ? PARTS : 2;
   localparam int unsigned SG_W  = $clog2(NSG);
   localparam int unsigned KEY_W = SG_W + ADDR_W;
   localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   if (PARTS < 1 || (LANES % PARTS) != 0) begin : g_bad_parts
      $error("LANES must be a multiple of PARTS");
   end
   if ((LANES % 2) != 0) begin : g_bad_lanes
      $error("LANES must be even for the two-way atomic split");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover a 128-byte region");
   end

   // ---------------- request state ----------------
   logic [LANES*ADDR_W-1:0] addr_q;
   logic [2:0]              size_q;
   logic                    atomic_q;
   logic [LANES-1:0]        pend_q;
   logic [LANES-1:0]        grp;
   logic                    take;
   logic                    fire;

   assign req_ready = ~|pend_q;
   assign take      = req_valid && req_ready;
   assign tx_valid  = |pend_q;
   assign fire      = tx_valid && tx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         size_q   <= '0;
         atomic_q <= 1'b0;
         pend_q   <= '0;
      end else if (take) begin
         addr_q   <= req_addr;
         size_q   <= req_size;
         atomic_q <= req_atomic;
         pend_q   <= req_mask;
      end else if (fire) begin
         pend_q <= pend_q & ~grp;
      end
   end

   // ---------------- per-lane decode ----------------
   logic [LANES*ADDR_W-1:0]       base;
   logic [LANES*SG_W-1:0]         sg;
   logic [LANES*REGION_BYTES-1:0] lane_bytes;
   logic [LANES*CHUNKS-1:0]       lane_chunks;
   logic [LANES*KEY_W-1:0]        key;

   coal_lane_decode #(
      .LANES(LANES), .ADDR_W(ADDR_W), .PARTS(PARTS), .SG_W(SG_W)
   ) u_decode (
      .addr_i   (addr_q),
      .size_i   (size_q),
      .atomic_i (atomic_q),
      .base_o   (base),
      .sg_o     (sg),
      .bytes_o  (lane_bytes),
      .chunks_o (lane_chunks)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_key
      assign key[l*KEY_W +: KEY_W] = {sg[l*SG_W +: SG_W], base[l*ADDR_W +: ADDR_W]};
   end

   // ---------------- leader, group, shrink ----------------
   logic [IDX_W-1:0]  lead;
   logic [CHUNKS-1:0] grp_chunks;
   logic [ADDR_W-1:0] lead_base;

   coal_pick #(
      .LANES(LANES), .KEY_W(KEY_W), .IDX_W(IDX_W)
   ) u_pick (
      .pend_i (pend_q),
      .key_i  (key),
      .lead_o (lead)
   );

   coal_group #(
      .LANES(LANES), .ADDR_W(ADDR_W), .SG_W(SG_W), .IDX_W(IDX_W)
   ) u_group (
      .pend_i       (pend_q),
      .base_i       (base),
      .sg_i         (sg),
      .bytes_i      (lane_bytes),
      .chunks_i     (lane_chunks),
      .lead_i       (lead),
      .atomic_i     (atomic_q),
      .grp_o        (grp),
      .grp_bytes_o  (tx_bytes),
      .grp_chunks_o (grp_chunks),
      .lead_base_o  (lead_base)
   );

   coal_shrink #(
      .ADDR_W(ADDR_W)
   ) u_shrink (
      .base_i     (lead_base),
      .acc_size_i (size_q),
      .chunks_i   (grp_chunks),
      .addr_o     (tx_addr),
      .size_o     (tx_size)
   );

   assign tx_lanes = grp;
   assign tx_last  = ~|(pend_q & ~grp);

   // ---------------- assertions ----------------
   p_size_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_size <= 3'd4);

   for (genvar l = 0; l < LANES; l++) begin : g_align_chk
      p_lane_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_mask[l]) |->
         (req_addr[l*ADDR_W +: 7] & 7'(acc_bytes(req_size) - 5'd1)) == 7'd0);
   end

   p_bytes_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_bytes & ~span_mask(tx_addr[6:0], 8'd32 << tx_size)) == '0);

   p_addr_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> tx_size != 2'd3 &&
                   (tx_addr[6:0] & 7'((8'd32 << tx_size) - 8'd1)) == 7'd0);

   p_lanes_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> tx_lanes != '0);

   p_no_reissue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !tx_valid || (tx_lanes & $past(tx_lanes)) == '0);

   p_atomic_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && atomic_q) |->
      $countones(tx_bytes) == $countones(tx_lanes) * int'(acc_bytes(size_q)));

   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_addr) && $stable(tx_size)
                                  && $stable(tx_lanes) && $stable(tx_bytes));

   p_idle_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && tx_last) |=> req_ready);

   p_empty_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_mask == '0) |=> req_ready && !tx_valid);

endmodule

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;

   localparam int  LANES      = 8;
   localparam int  ADDR_W     = 16;
   localparam int  PARTS      = 2;
   localparam time CLK_PERIOD = 10;

   logic                    clk;
   logic                    rst_n;
   logic                    req_valid;
   logic                    req_ready;
   logic                    req_atomic;
   logic [2:0]              req_size;
   logic [LANES-1:0]        req_mask;
   logic [LANES*ADDR_W-1:0] req_addr;
   logic                    tx_valid;
   logic                    tx_ready;
   logic [ADDR_W-1:0]       tx_addr;
   logic [1:0]              tx_size;
   logic [LANES-1:0]        tx_lanes;
   logic [127:0]            tx_bytes;
   logic                    tx_last;

   warp_coalescer #(.LANES(LANES), .ADDR_W(ADDR_W), .PARTS(PARTS)) u_warp_coalescer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_atomic(req_atomic),
      .req_size(req_size), .req_mask(req_mask), .req_addr(req_addr),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr),
      .tx_size(tx_size), .tx_lanes(tx_lanes), .tx_bytes(tx_bytes), .tx_last(tx_last)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // stimulus
   logic [ADDR_W-1:0] stim_addr [LANES];
   logic [LANES-1:0]  stim_mask;
   logic [2:0]        stim_size;
   logic              stim_atomic;

   // expected transactions
   typedef struct {
      logic [ADDR_W-1:0] base;
      logic [ADDR_W-1:0] addr;
      logic [1:0]        size;
      logic [LANES-1:0]  lanes;
      logic [127:0]      bytes;
   } exp_t;
   exp_t exp_q [LANES];
   int   exp_n;

   task automatic chk(input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // list-based model: first-fit per sub-group, stable sort by base, chunk-span shrink
   task automatic build_expected();
      int nsg, gsz, segb, nb;
      nsg  = stim_atomic ? 2 : PARTS;
      gsz  = LANES / nsg;
      segb = (stim_size == 0) ? 32 : (stim_size == 1) ? 64 : 128;
      nb   = 1 << stim_size;
      exp_n = 0;
      for (int g = 0; g < nsg; g++) begin
         int first;
         first = exp_n;
         for (int l = g*gsz; l < (g+1)*gsz; l++) begin
            if (stim_mask[l]) begin
               logic [ADDR_W-1:0] b;
               logic [127:0]      lm;
               int                slot;
               b    = stim_addr[l] & ~ADDR_W'(segb - 1);
               lm   = ((128'(1) << nb) - 128'(1)) << (stim_addr[l] % 128);
               slot = -1;
               for (int t = first; t < exp_n; t++) begin
                  if (slot < 0 && exp_q[t].base == b &&
                      (!stim_atomic || (exp_q[t].bytes & lm) == '0))
                     slot = t;
               end
               if (slot < 0) begin
                  slot = exp_n;
                  exp_n++;
                  exp_q[slot].base  = b;
                  exp_q[slot].lanes = '0;
                  exp_q[slot].bytes = '0;
               end
               exp_q[slot].lanes[l] = 1'b1;
               exp_q[slot].bytes    = exp_q[slot].bytes | lm;
            end
         end
         for (int i = first + 1; i < exp_n; i++) begin
            for (int j = i; j > first; j--) begin
               if (exp_q[j-1].base > exp_q[j].base) begin
                  exp_t tmp;
                  tmp        = exp_q[j];
                  exp_q[j]   = exp_q[j-1];
                  exp_q[j-1] = tmp;
               end
            end
         end
      end
      for (int t = 0; t < exp_n; t++) begin
         int lo, hi;
         logic [ADDR_W-1:0] r;
         lo = -1; hi = -1;
         for (int c = 0; c < 4; c++) begin
            if (|exp_q[t].bytes[c*32 +: 32]) begin
               if (lo < 0) lo = c;
               hi = c;
            end
         end
         r = exp_q[t].base & ~ADDR_W'(127);
         if ((lo >> 1) != (hi >> 1)) begin
            exp_q[t].addr = r;
            exp_q[t].size = 2'd2;
         end else if (lo != hi) begin
            exp_q[t].addr = r + ADDR_W'((lo >> 1) * 64);
            exp_q[t].size = 2'd1;
         end else begin
            exp_q[t].addr = r + ADDR_W'(lo * 32);
            exp_q[t].size = 2'd0;
         end
      end
   endtask

   task automatic run_req(input string tag, input bit stall);
      int idx, cyc;
      build_expected();
      @(negedge clk);
      chk(tag, "req_ready before request", req_ready, 1);
      for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = stim_addr[l];
      req_mask   = stim_mask;
      req_size   = stim_size;
      req_atomic = stim_atomic;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      idx = 0;
      cyc = 0;
      while (idx < exp_n && cyc < 100) begin
         tx_ready = !stall || (cyc % 3 != 1);
         #1;
         chk(tag, "tx_valid", tx_valid, 1);
         chk(tag, "req_ready while busy", req_ready, 0);
         chk(tag, "tx_addr",  tx_addr,  exp_q[idx].addr);
         chk(tag, "tx_size",  tx_size,  exp_q[idx].size);
         chk(tag, "tx_lanes", tx_lanes, exp_q[idx].lanes);
         chk(tag, "tx_bytes", tx_bytes, exp_q[idx].bytes);
         chk(tag, "tx_last",  tx_last,  idx == exp_n - 1);
         if (tx_ready && tx_valid) idx++;
         @(negedge clk);
         cyc++;
      end
      tx_ready = 1'b0;
      #1;
      chk(tag, "tx_valid after stream", tx_valid, 0);
      chk(tag, "req_ready after stream", req_ready, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      req_valid  = 1'b0;
      req_atomic = 1'b0;
      req_size   = '0;
      req_mask   = '0;
      req_addr   = '0;
      tx_ready   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R9", "reset tx_valid",  tx_valid, 0);
      chk("R9", "reset req_ready", req_ready, 1);

      // R1: byte accesses use 32-byte segments
      stim_atomic = 0; stim_size = 3'd0; stim_mask = '1;
      for (int l = 0; l < LANES; l++) stim_addr[l] = ADDR_W'((l < 4) ? 'h100 + l : 'h120 + l);
      run_req("R1", 0);

      // R2 and R10: contiguous words share one transaction per sub-group
      stim_size = 3'd2;
      for (int l = 0; l < LANES; l++) stim_addr[l] = ADDR_W'('h100 + 4*l);
      run_req("R2", 0);
      run_req("R10", 0);

      // R3: sparse mask with 8-byte accesses
      stim_size = 3'd3; stim_mask = 8'b1010_0101;
      for (int l = 0; l < LANES; l++) stim_addr[l] = ADDR_W'('h200 + 8*l);
      run_req("R3", 0);

      // R4: upper and lower 64-byte halves of 128-byte segments
      stim_size = 3'd2; stim_mask = '1;
      for (int l = 0; l < LANES; l++) stim_addr[l] = ADDR_W'('h340 + 16*l);
      run_req("R4", 0);

      // R5: native 64-byte segment, upper half only
      stim_size = 3'd1;
      for (int l = 0; l < LANES; l++) stim_addr[l] = ADDR_W'('h1E0 + 2*l);
      run_req("R5", 0);

      // R6: atomic, every lane on the same word
      stim_size = 3'd2; stim_atomic = 1;
      for (int l = 0; l < LANES; l++) stim_addr[l] = ADDR_W'('h500);
      run_req("R6", 0);

      // R7: descending addresses come out ascending
      stim_atomic = 0;
      for (int l = 0; l < LANES; l++) stim_addr[l] = ADDR_W'('h900 - 128*l);
      run_req("R7", 0);

      // R8: empty mask
      stim_mask = '0;
      run_req("R8", 0);

      // R9: backpressure
      stim_mask = '1;
      for (int l = 0; l < LANES; l++) stim_addr[l] = ADDR_W'('h700 + 40*l);
      run_req("R9", 1);

      // sweep: sizes x atomic x patterns x stall
      for (int sz = 0; sz < 5; sz++) begin
         for (int at = 0; at < 2; at++) begin
            for (int p = 0; p < 6; p++) begin
               for (int st = 0; st < 2; st++) begin
                  int nb;
                  nb = 1 << sz;
                  stim_size   = 3'(sz);
                  stim_atomic = at[0];
                  stim_mask   = st[0] ? LANES'($urandom) : '1;
                  for (int l = 0; l < LANES; l++) begin
                     case (p)
                        0: stim_addr[l] = ADDR_W'('h400 + l*nb);
                        1: stim_addr[l] = ADDR_W'('h800);
                        2: stim_addr[l] = ADDR_W'('hC00 + l*32);
                        3: stim_addr[l] = ADDR_W'('h1000 + (LANES-1-l)*64);
                        4: stim_addr[l] = ADDR_W'('h1400 + (l/2)*nb);
                        default: stim_addr[l] = ADDR_W'($urandom) & ~ADDR_W'(nb - 1);
                     endcase
                  end
                  run_req(at ? "R6" : "R2", st[0]);
               end
            end
         end
      end

      // random requests inside a small address window to force sharing
      for (int k = 0; k < 100; k++) begin
         int nb;
         stim_size   = 3'($urandom % 5);
         nb          = 1 << stim_size;
         stim_atomic = $urandom % 2;
         stim_mask   = LANES'($urandom);
         for (int l = 0; l < LANES; l++)
            stim_addr[l] = ADDR_W'('h2000 + ($urandom % 512)) & ~ADDR_W'(nb - 1);
         run_req("R7", k[0]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule